// File: doc/BRIEF.md
# Debug Monitor Entry Sequencer

This block chooses, once per reset, whether a small controller comes up in a serial debug monitor or in normal user operation. The choice is made when the internal, synchronised reset deasserts. At that moment the block looks at three pin inputs: a mode-select pin bundle, a flag saying that a high test voltage is present, and a flag saying that the reset was a power-on reset. It keeps the result until the next reset, whatever the pins do afterwards.

In monitor operation the host must first send a fixed number of security bytes. A serial receiver outside this block signals each one with a byte-valid strobe. After the last byte the block holds its transmit line low for ten bit periods, which form a break, and then reports that it is ready to accept commands. A separate bit-clock enable marks the bit periods.

While monitor operation is active, the block also does two more things. On vector fetches it replaces the high address byte with the monitor vector page. It also keeps the watchdog off for as long as the high test voltage is present.

Top module: `mon_entry_seq`

## Requirements
- R1: At reset release, `mon_mode` becomes 1 only if `sel_pins` equals 3'b101 (bit 2 high, bit 1 low, bit 0 high), `hv_detect` is 1 and `por_flag` is 1. Otherwise it becomes 0. The value is valid from the third rising clock edge after `rst_n` rises.
- R2: Once the mode has been captured, changes on `sel_pins`, `hv_detect` or `por_flag` never change `mon_mode`.
- R3: In monitor operation, `tx_bit` stays 1 until exactly eight `rx_byte_valid` strobes have arrived. Any `bit_tick` pulses before that point have no effect.
- R4: The clock edge that takes the eighth byte drives `tx_bit` to 0. `tx_bit` then stays 0 across exactly ten `bit_tick` pulses and returns to 1 on the edge that takes the tenth.
- R5: `break_done` is high for exactly one cycle, on the same edge at which `tx_bit` returns to 1. From that edge on, `cmd_ready` is 1 and stays 1.
- R6: Byte strobes that arrive during the break or after `cmd_ready` have no effect on `tx_bit`, `break_done` or `cmd_ready`.
- R7: In user operation, `tx_bit` stays 1 and both `cmd_ready` and `break_done` stay 0, whatever strobes or ticks arrive.
- R8: When `vec_fetch` is 1, `addr_hi_out` is 8'hFE in monitor operation and 8'hFF in user operation. When `vec_fetch` is 0, `addr_hi_out` passes `cpu_addr_hi` through unchanged.
- R9: `wdog_en` is 0 exactly when `mon_mode` is 1 and `hv_detect` is 1 at that moment. Otherwise it is 1.
- R10: While `rst_n` is low, `mon_mode` = 0, `tx_bit` = 1, `break_done` = 0 and `cmd_ready` = 0. The reset also clears the byte count, so a reset in the middle of the sequence requires a full eight new bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_flag | input | 1 | The reset in progress is a power-on reset |
| sel_pins | input | 3 | Mode-select pin levels |
| hv_detect | input | 1 | High test voltage present on the interrupt or reset pin |
| rx_byte_valid | input | 1 | One-cycle strobe per byte received from the host |
| bit_tick | input | 1 | One-cycle enable per serial bit period |
| vec_fetch | input | 1 | The CPU is fetching an interrupt or reset vector |
| cpu_addr_hi | input | 8 | High address byte from the CPU |
| mon_mode | output | 1 | Monitor operation latched |
| wdog_en | output | 1 | Watchdog enable |
| addr_hi_out | output | 8 | High address byte after vector page substitution |
| tx_bit | output | 1 | Serial transmit level (idles high) |
| break_done | output | 1 | One-cycle pulse at the end of the break |
| cmd_ready | output | 1 | The monitor is ready for commands |

## Verification
A byte counter that is off by one shows up as `tx_bit` falling one strobe early or one strobe late. This is visible on the very edge that takes the strobe, so the bench checks the line after every byte. A break counter error shows up as a low period of nine or eleven ticks, with `break_done` and `cmd_ready` appearing on the wrong tick. A mode latch that keeps following the pins shows up on `mon_mode`, `wdog_en` and `addr_hi_out` in the cycle after a pin change, so the bench flips the pins once entry is complete and checks all three.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_SECURE,
    ST_BREAK,
    ST_CMD,
    ST_USER
  } seq_state_e;

  localparam logic [7:0] PAGE_MON  = 8'hFE;
  localparam logic [7:0] PAGE_USER = 8'hFF;
endpackage

// File: rtl/mon_rst_sync.sv
module mon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_int_n = sh_q[STAGES-1];
endmodule

// File: rtl/mon_mode_latch.sv
module mon_mode_latch #(
  parameter int              PIN_W         = 3,
  parameter logic [PIN_W-1:0] ENTRY_PATTERN = 3'b101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] sel_pins,
  input  logic             hv_detect,
  input  logic             por_flag,
  output logic             captured,
  output logic             mode
);
  logic captured_q, captured_d;
  logic mode_q, mode_d;
  logic enter_cond;

  assign enter_cond = (sel_pins == ENTRY_PATTERN) && hv_detect && por_flag;

  always_comb begin
    captured_d = captured_q;
    mode_d     = mode_q;
    if (!captured_q) begin
      captured_d = 1'b1;
      mode_d     = enter_cond;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured_q <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      captured_q <= captured_d;
      mode_q     <= mode_d;
    end
  end

  assign captured = captured_q;
  assign mode     = mode_q;

  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    captured_q |=> (captured_q && $stable(mode_q)));
endmodule

// File: rtl/mon_seq_fsm.sv
module mon_seq_fsm
  import mon_pkg::*;
#(
  parameter int SEC_BYTES  = 8,
  parameter int BREAK_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic captured,
  input  logic mode,
  input  logic byte_vld,
  input  logic bit_tick,
  output logic tx_bit,
  output logic break_done,
  output logic cmd_ready
);
  localparam int MAXC  = (SEC_BYTES > BREAK_BITS) ? SEC_BYTES : BREAK_BITS;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(SEC_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BREAK_BITS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             tx_q, tx_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    case (state_q)
      ST_HOLD: begin
        cnt_d = '0;
        if (captured) state_d = mode ? ST_SECURE : ST_USER;
      end
      ST_SECURE: begin
        if (byte_vld) begin
          if (cnt_q == LAST_BYTE) begin
            state_d = ST_BREAK;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_BREAK: begin
        if (bit_tick) begin
          if (cnt_q == LAST_BIT) begin
            state_d = ST_CMD;
            cnt_d   = '0;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = state_q;
      end
    endcase
    tx_d = (state_d != ST_BREAK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      tx_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      tx_q    <= tx_d;
    end
  end

  assign tx_bit     = tx_q;
  assign break_done = done_q;
  assign cmd_ready  = (state_q == ST_CMD);

  assert_sec_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SECURE) |-> (cnt_q < CNT_W'(SEC_BYTES)));
  assert_break_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BREAK) |-> (cnt_q < CNT_W'(BREAK_BITS)));
  assert_tx_low_only_in_break_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_q |-> (state_q == ST_BREAK));
  assert_done_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_ready_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD) |=> (state_q == ST_CMD));
  assert_user_no_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_USER) |=> ((state_q == ST_USER) && tx_q && !done_q));
endmodule

// File: rtl/mon_mode_apply.sv
module mon_mode_apply
  import mon_pkg::*;
(
  input  logic       mode,
  input  logic       hv_detect,
  input  logic       vec_fetch,
  input  logic [7:0] cpu_addr_hi,
  output logic [7:0] addr_hi_out,
  output logic       wdog_en
);
  always_comb begin
    if (vec_fetch) addr_hi_out = mode ? PAGE_MON : PAGE_USER;
    else           addr_hi_out = cpu_addr_hi;
    wdog_en = !(mode && hv_detect);
  end
endmodule

// File: rtl/mon_entry_seq.sv
module mon_entry_seq #(
  parameter int               PIN_W         = 3,
  parameter logic [PIN_W-1:0] ENTRY_PATTERN = 3'b101,
  parameter int               SEC_BYTES     = 8,
  parameter int               BREAK_BITS    = 10,
  parameter int               SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_flag,
  input  logic [PIN_W-1:0] sel_pins,
  input  logic             hv_detect,
  input  logic             rx_byte_valid,
  input  logic             bit_tick,
  input  logic             vec_fetch,
  input  logic [7:0]       cpu_addr_hi,
  output logic             mon_mode,
  output logic             wdog_en,
  output logic [7:0]       addr_hi_out,
  output logic             tx_bit,
  output logic             break_done,
  output logic             cmd_ready
);
  logic rst_int_n;
  logic captured;
  logic mode;

  mon_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  mon_mode_latch #(.PIN_W(PIN_W), .ENTRY_PATTERN(ENTRY_PATTERN)) u_latch (
    .clk(clk), .rst_n(rst_int_n), .sel_pins(sel_pins), .hv_detect(hv_detect),
    .por_flag(por_flag), .captured(captured), .mode(mode)
  );

  mon_seq_fsm #(.SEC_BYTES(SEC_BYTES), .BREAK_BITS(BREAK_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .captured(captured), .mode(mode),
    .byte_vld(rx_byte_valid), .bit_tick(bit_tick), .tx_bit(tx_bit),
    .break_done(break_done), .cmd_ready(cmd_ready)
  );

  mon_mode_apply u_apply (
    .mode(mode), .hv_detect(hv_detect), .vec_fetch(vec_fetch),
    .cpu_addr_hi(cpu_addr_hi), .addr_hi_out(addr_hi_out), .wdog_en(wdog_en)
  );

  assign mon_mode = mode;

  assert_wdog_gate_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wdog_en |-> (mon_mode && hv_detect));
  assert_vector_page_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    vec_fetch |-> (addr_hi_out[7:1] == 7'h7F && addr_hi_out[0] == !mon_mode));
  assert_ready_needs_monitor_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_ready |-> mon_mode);
endmodule

// File: tb/mon_entry_seq_test.sv
module mon_entry_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       por_flag;
  logic [2:0] sel_pins;
  logic       hv_detect;
  logic       rx_byte_valid;
  logic       bit_tick;
  logic       vec_fetch;
  logic [7:0] cpu_addr_hi;
  logic       mon_mode, wdog_en, tx_bit, break_done, cmd_ready;
  logic [7:0] addr_hi_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  mon_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .por_flag(por_flag), .sel_pins(sel_pins),
    .hv_detect(hv_detect), .rx_byte_valid(rx_byte_valid), .bit_tick(bit_tick),
    .vec_fetch(vec_fetch), .cpu_addr_hi(cpu_addr_hi), .mon_mode(mon_mode),
    .wdog_en(wdog_en), .addr_hi_out(addr_hi_out), .tx_bit(tx_bit),
    .break_done(break_done), .cmd_ready(cmd_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply_reset(input logic [2:0] p, input logic hv, input logic por, input bit check_rst);
    @(negedge clk);
    rst_n = 1'b0;
    sel_pins = p; hv_detect = hv; por_flag = por;
    rx_byte_valid = 1'b0; bit_tick = 1'b0;
    repeat (3) @(negedge clk);
    if (check_rst) begin
      chk("R10 mon_mode in reset", int'(mon_mode), 0);
      chk("R10 tx_bit in reset", int'(tx_bit), 1);
      chk("R10 break_done in reset", int'(break_done), 0);
      chk("R10 cmd_ready in reset", int'(cmd_ready), 0);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_byte();
    rx_byte_valid = 1'b1;
    @(negedge clk);
    rx_byte_valid = 1'b0;
  endtask

  task automatic pulse_tick();
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  // Full monitor entry; junk = number of bytes injected during the break
  task automatic run_monitor(input int junk);
    apply_reset(3'b101, 1'b1, 1'b1, 1'b0);
    chk("R1 monitor entry", int'(mon_mode), 1);
    for (int b = 0; b < 8; b++) begin
      pulse_tick();
      chk("R3 tick before bytes ignored", int'(tx_bit), 1);
      @(negedge clk);
      pulse_byte();
      chk("R3 tx after byte", int'(tx_bit), (b == 7) ? 0 : 1);
      chk("R3 not ready during security", int'(cmd_ready), 0);
    end
    for (int k = 1; k <= 10; k++) begin
      if (k <= junk) begin
        pulse_byte();
        chk("R6 byte during break", int'(tx_bit), 0);
      end
      chk("R4 low before tick", int'(tx_bit), 0);
      pulse_tick();
      chk("R4 tx after tick", int'(tx_bit), (k == 10) ? 1 : 0);
      chk("R5 done pulse timing", int'(break_done), (k == 10) ? 1 : 0);
      chk("R5 ready timing", int'(cmd_ready), (k == 10) ? 1 : 0);
    end
    @(negedge clk);
    chk("R5 done is single cycle", int'(break_done), 0);
    chk("R5 ready held", int'(cmd_ready), 1);
    pulse_byte();
    pulse_tick();
    chk("R6 byte after ready tx", int'(tx_bit), 1);
    chk("R6 byte after ready done", int'(break_done), 0);
    chk("R6 byte after ready", int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; por_flag = 1'b0; sel_pins = '0; hv_detect = 1'b0;
    rx_byte_valid = 1'b0; bit_tick = 1'b0; vec_fetch = 1'b0; cpu_addr_hi = '0;

    // R1, R2, R9, R10: sweep every pin/voltage/power-on combination
    for (int c = 0; c < 32; c++) begin
      logic [2:0] p;
      logic hv, por, exp_m;
      p = c[2:0]; hv = c[3]; por = c[4];
      exp_m = (p == 3'b101) && hv && por;
      apply_reset(p, hv, por, (c % 4) == 0);
      chk("R1 mode capture", int'(mon_mode), int'(exp_m));
      chk("R9 watchdog gate", int'(wdog_en), int'(!(exp_m && hv)));
      sel_pins = ~p; hv_detect = ~hv; por_flag = ~por;
      repeat (3) @(negedge clk);
      chk("R2 pins ignored after capture", int'(mon_mode), int'(exp_m));
      chk("R9 watchdog follows live voltage", int'(wdog_en), int'(!(exp_m && !hv)));
      vec_fetch = 1'b1; #1;
      chk("R8 vector page", int'(addr_hi_out), exp_m ? 254 : 255);
      vec_fetch = 1'b0;
    end

    // R7: user operation ignores bytes and ticks
    apply_reset(3'b100, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) begin
      pulse_byte();
      pulse_tick();
      chk("R7 user tx idle", int'(tx_bit), 1);
      chk("R7 user never ready", int'(cmd_ready) + int'(break_done), 0);
    end

    // R3-R6 with 0..3 bytes injected during the break
    for (int j = 0; j < 4; j++) run_monitor(j);

    // R10: reset in the middle of security clears the byte count
    apply_reset(3'b101, 1'b1, 1'b1, 1'b0);
    for (int b = 0; b < 5; b++) pulse_byte();
    apply_reset(3'b101, 1'b1, 1'b1, 1'b1);
    for (int b = 0; b < 7; b++) pulse_byte();
    chk("R10 count cleared by reset", int'(tx_bit), 1);
    pulse_byte();
    chk("R10 break after eight fresh bytes", int'(tx_bit), 0);

    // R8: full address sweep in monitor and user operation
    for (int m = 0; m < 2; m++) begin
      apply_reset(m[0] ? 3'b101 : 3'b000, 1'b1, 1'b1, 1'b0);
      for (int a = 0; a < 256; a++) begin
        for (int f = 0; f < 2; f++) begin
          @(negedge clk);
          cpu_addr_hi = a[7:0]; vec_fetch = f[0]; #1;
          chk("R8 address substitution", int'(addr_hi_out), f[0] ? (m[0] ? 254 : 255) : a);
        end
      end
      vec_fetch = 1'b0;
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule